// File: doc/BRIEF.md
# Teletext Packet Decoder with Magazine Cache

This block takes teletext packets that have already been recovered and framed into bytes. It removes the error protection from each packet and labels every data byte it emits with the packet's magazine, row, page number, subcode and serial-mode flag. The input is one byte per accepted cycle while a frame signal is high. A packet is 42 bytes: two address bytes, then the payload.

Only a header row (row 0) carries the page number, subcode and control bits. Other rows carry only their magazine. In parallel transmission, rows of different magazines arrive interleaved, so the block keeps one cache entry per magazine. A header that decodes cleanly writes its magazine's entry. Every later row of that magazine is labelled from that entry. Downstream logic, such as page selection and display RAM writes, consumes the labelled byte stream.

Top module: `tpd_packet_decoder`

## Requirements
- R1: A packet is the run of bytes accepted (in_valid high) while in_frame is high, counted from 0. Bytes at position 42 and beyond, and cycles with in_valid low, produce no output. Dropping in_frame for a cycle restarts the count at 0.
- R2: Protected bytes use an 8/4 Hamming code. Data bits d1..d4 (nibble bits 0..3) sit at byte bits 1, 3, 5 and 7. Check bits sit at bits 0, 2 and 4: p1=NOT(d1^d3^d4), p2=NOT(d1^d2^d4), p3=NOT(d1^d2^d3). Bit 6 makes the byte's parity odd. Any single flipped bit is corrected. Any two flipped bits make the byte uncorrectable.
- R3: Bytes 0 and 1 are the address. The byte 0 nibble holds the magazine in bits 2..0 and row bit 0 in bit 3. The byte 1 nibble holds row bits 4..1. A magazine value of 0 is reported as 8 on out_mag. A packet with an uncorrectable address byte produces no output at all.
- R4: In a header (row 0), bytes 2..9 carry nibbles h0..h7, with these meanings:
  - page = {h1,h0}
  - subcode = {h5[1:0],h4,h3[2:0],h2}
  - serial flag = h7 bit 0
  
  When all of them decode, the magazine's cache entry is written. The labels take the new values, and hdr_stored pulses for one cycle, in the cycle after byte 9 is accepted.
- R5: A header with any uncorrectable nibble in bytes 2..9 is discarded. It leaves the cache unchanged, emits no bytes and gives no hdr_stored pulse.
- R6: A non-header row is labelled with its magazine's cached page, subcode and serial flag. out_known shows whether that magazine has stored a header since reset.
- R7: For rows 0..24, each payload byte is checked for odd parity over 8 bits. A passing byte is emitted with bit 7 cleared. A failing byte is emitted as 0x20 with out_perr high.
- R8: Each emitted byte appears with out_valid one cycle after it is accepted, with out_col equal to its position minus 2. Headers emit positions 10..41 (columns 8..39). Other rows emit positions 2..41.
- R9: For rows 25..31, payload bytes are emitted unchanged with out_nondisp high, and no parity check is applied.
- R10: After reset, every output is 0 and every cache entry is unknown.
- R11: A header of one magazine never changes the labels later given to rows of another magazine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_frame | input | 1 | High for the duration of one packet |
| in_valid | input | 1 | in_byte carries a packet byte this cycle |
| in_byte | input | 8 | Packet byte |
| out_valid | output | 1 | Emitted payload byte is present |
| out_col | output | 6 | Payload column (byte position minus 2) |
| out_byte | output | 8 | Processed payload byte |
| out_perr | output | 1 | Parity failure on this byte |
| out_mag | output | 4 | Magazine 1..8 of the labels |
| out_row | output | 5 | Row of the labels |
| out_page | output | 8 | Page tens and units nibbles |
| out_sub | output | 13 | Subcode |
| out_serial | output | 1 | Serial-mode flag from the governing header |
| out_known | output | 1 | A header has labelled this magazine since reset |
| out_nondisp | output | 1 | Row is 25 or higher |
| hdr_stored | output | 1 | One-cycle pulse: a header was written to the cache |

## Verification
Two functions can fall on the same edge. The last header nibble (byte 9) is Hamming-corrected live, and that same edge writes the corrected nibble into the cache, relabels the output and raises hdr_stored. The bench provokes this in two ways: by flipping single bits in byte 9 and in the other header bytes, and by sending a row of the same magazine directly after a header. It then checks two things: that the header's own display bytes carry the newly written page and serial flag, and that the following row carries them too. A stale value fails both checks, and so does a value that was written before correction.

// File: rtl/tpd_pkg.sv
// Package: shared widths and the cache entry type of the teletext packet decoder.
// Assumes a 3-bit magazine field and the fixed header nibble layout.
package tpd_pkg;
    localparam int MAG_W      = 3;
    localparam int ROW_W      = 5;
    localparam int NIB_W      = 4;
    localparam int PAGE_W     = 2 * NIB_W;
    localparam int SUB_W      = 13;
    localparam int HDR_NIBS   = 8;
    localparam int ADDR_BYTES = 2;

    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic              known;
        logic              serial;
        logic [PAGE_W-1:0] page;
        logic [SUB_W-1:0]  sub;
    } mag_entry_t;
endpackage

// File: rtl/tpd_ham84_dec.sv
// Module: combinational 8/4 Hamming decoder.
// Data bits sit at byte bits 1,3,5,7; checks at 0,2,4; bit 6 sets odd overall parity.
// Corrects one flipped bit, flags two flipped bits as uncorrectable.
module tpd_ham84_dec
    import tpd_pkg::*;
(
    input  logic [7:0] code,
    output nib_t       data,
    output logic       corrected,
    output logic       uncorrectable
);
    logic fail_a, fail_b, fail_c, parity_ok, any_fail;

    // Purpose: evaluate the three check groups and overall parity, then repair.
    always_comb begin
        fail_a    = ~(code[0] ^ code[1] ^ code[5] ^ code[7]);
        fail_b    = ~(code[2] ^ code[1] ^ code[3] ^ code[7]);
        fail_c    = ~(code[4] ^ code[1] ^ code[3] ^ code[5]);
        parity_ok = ^code;
        any_fail  = fail_a | fail_b | fail_c;
        data      = {code[7], code[5], code[3], code[1]};
        corrected     = 1'b0;
        uncorrectable = 1'b0;
        if (parity_ok) begin
            uncorrectable = any_fail;
        end else begin
            corrected = 1'b1;
            data[0] = data[0] ^ ( fail_a &  fail_b &  fail_c);
            data[1] = data[1] ^ (~fail_a &  fail_b &  fail_c);
            data[2] = data[2] ^ ( fail_a & ~fail_b &  fail_c);
            data[3] = data[3] ^ ( fail_a &  fail_b & ~fail_c);
        end
    end
endmodule

// File: rtl/tpd_parity_chk.sv
// Module: odd-parity check of one payload byte.
// Emits the 7-bit character; on failure emits a space or the stripped byte,
// depending on ERR_TO_SPACE.
module tpd_parity_chk #(
    parameter bit ERR_TO_SPACE = 1'b1
) (
    input  logic [7:0] raw,
    output logic [7:0] ch,
    output logic       err
);
    logic [7:0] stripped, on_fail;

    // Purpose: parity verdict and stripped character.
    always_comb begin
        err      = ~(^raw);
        stripped = {1'b0, raw[6:0]};
    end

    generate
        if (ERR_TO_SPACE) begin : g_space
            assign on_fail = 8'h20;
        end else begin : g_keep
            assign on_fail = stripped;
        end
    endgenerate

    // Purpose: choose the emitted character.
    always_comb ch = err ? on_fail : stripped;
endmodule

// File: rtl/tpd_mag_cache.sv
// Module: one page/subcode entry per magazine.
// Write port is registered; read port is combinational. Reset marks all entries unknown.
module tpd_mag_cache
    import tpd_pkg::*;
#(
    parameter int IDX_W = MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  mag_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output mag_entry_t       rd_entry
);
    localparam int NUM = 1 << IDX_W;

    mag_entry_t       slot [NUM];
    logic [NUM-1:0]   known_vec;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_slot
            // Purpose: hold the latest header fields of magazine g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    slot[g] <= wr_entry;
            end
            assign known_vec[g] = slot[g].known;
        end
    endgenerate

    // Purpose: lookup for the row being labelled.
    always_comb rd_entry = slot[rd_idx];

    a_r4_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot[$past(wr_idx)] == $past(wr_entry));

    a_r10_unknown_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> known_vec == '0);
endmodule

// File: rtl/tpd_packet_decoder.sv
// Module: teletext packet decoder with per-magazine header cache (top).
// Assumes framed bytes, one per in_valid cycle inside in_frame, with at least
// one in_frame-low cycle between packets. Emits labelled payload bytes one cycle
// after they are accepted.
module tpd_packet_decoder
    import tpd_pkg::*;
#(
    parameter int PKT_BYTES         = 42,
    parameter bit ERR_TO_SPACE      = 1'b1,
    parameter int FIRST_NONDISP_ROW = 25
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_frame,
    input  logic                                in_valid,
    input  logic [7:0]                          in_byte,
    output logic                                out_valid,
    output logic [$clog2(PKT_BYTES-2)-1:0]      out_col,
    output logic [7:0]                          out_byte,
    output logic                                out_perr,
    output logic [3:0]                          out_mag,
    output logic [4:0]                          out_row,
    output logic [7:0]                          out_page,
    output logic [12:0]                         out_sub,
    output logic                                out_serial,
    output logic                                out_known,
    output logic                                out_nondisp,
    output logic                                hdr_stored
);
    localparam int IDX_W    = $clog2(PKT_BYTES + 1);
    localparam int COL_W    = $clog2(PKT_BYTES - ADDR_BYTES);
    localparam int HDR_LAST = ADDR_BYTES + HDR_NIBS - 1;
    localparam int NUM_MAG  = 1 << MAG_W;

    logic [IDX_W-1:0] byte_idx;
    logic             alive, addr_bad, hdr_bad;
    nib_t             addr_lo;
    logic [MAG_W-1:0] cur_mag, new_mag;
    logic [ROW_W-1:0] cur_row, new_row;
    nib_t             hdr_nib [HDR_NIBS-1];

    nib_t             dec_data;
    logic             dec_fix, dec_unc;
    logic [7:0]       pc_char;
    logic             pc_err;

    logic take, at_addr_hi, at_hdr_last, is_hdr, addr_good, row_load, cache_we, emit, cur_nondisp;
    mag_entry_t rd_entry, wr_entry, lab_entry;
    logic [MAG_W:0]   lab_mag;
    logic [ROW_W-1:0] lab_row;
    logic             lab_nondisp;

    tpd_ham84_dec u_ham (
        .code          (in_byte),
        .data          (dec_data),
        .corrected     (dec_fix),
        .uncorrectable (dec_unc)
    );

    tpd_parity_chk #(.ERR_TO_SPACE(ERR_TO_SPACE)) u_par (
        .raw (in_byte),
        .ch  (pc_char),
        .err (pc_err)
    );

    tpd_mag_cache #(.IDX_W(MAG_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cache_we),
        .wr_idx   (cur_mag),
        .wr_entry (wr_entry),
        .rd_idx   (new_mag),
        .rd_entry (rd_entry)
    );

    // Purpose: magazine code 0 is reported as the highest magazine.
    function automatic logic [MAG_W:0] mag_report(input logic [MAG_W-1:0] m);
        return (m == '0) ? (MAG_W+1)'(NUM_MAG) : {1'b0, m};
    endfunction

    // Purpose: per-cycle decisions on the accepted byte.
    always_comb begin
        take        = in_frame && in_valid && (byte_idx < IDX_W'(PKT_BYTES));
        at_addr_hi  = byte_idx == IDX_W'(ADDR_BYTES - 1);
        at_hdr_last = byte_idx == IDX_W'(HDR_LAST);
        new_mag     = addr_lo[MAG_W-1:0];
        new_row     = {dec_data, addr_lo[NIB_W-1]};
        addr_good   = !addr_bad && !dec_unc;
        is_hdr      = cur_row == '0;
        cur_nondisp = cur_row >= ROW_W'(FIRST_NONDISP_ROW);
        row_load    = take && at_addr_hi && addr_good && (new_row != '0);
        cache_we    = take && alive && is_hdr && at_hdr_last && !hdr_bad && !dec_unc;
        emit        = take && alive && (byte_idx >= IDX_W'(ADDR_BYTES))
                      && (!is_hdr || byte_idx > IDX_W'(HDR_LAST));
    end

    // Purpose: assemble the header fields, the last nibble taken live.
    always_comb begin
        wr_entry.known  = 1'b1;
        wr_entry.serial = dec_data[0];
        wr_entry.page   = {hdr_nib[1], hdr_nib[0]};
        wr_entry.sub    = {hdr_nib[5][1:0], hdr_nib[4], hdr_nib[3][2:0], hdr_nib[2]};
    end

    // Purpose: byte position within the packet and the packet-alive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            alive    <= 1'b1;
        end else if (!in_frame) begin
            byte_idx <= '0;
            alive    <= 1'b1;
        end else if (take) begin
            byte_idx <= byte_idx + 1'b1;
            if (at_addr_hi && !addr_good)
                alive <= 1'b0;
            if (at_hdr_last && is_hdr && (hdr_bad || dec_unc))
                alive <= 1'b0;
        end
    end

    // Purpose: capture the two address nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo  <= '0;
            addr_bad <= 1'b0;
            cur_mag  <= '0;
            cur_row  <= '0;
        end else if (take) begin
            if (byte_idx == '0) begin
                addr_lo  <= dec_data;
                addr_bad <= dec_unc;
            end
            if (at_addr_hi && addr_good) begin
                cur_mag <= new_mag;
                cur_row <= new_row;
            end
        end
    end

    // Purpose: collect header nibbles and accumulate their error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_NIBS - 1; i++) hdr_nib[i] <= '0;
            hdr_bad <= 1'b0;
        end else if (take) begin
            for (int i = 0; i < HDR_NIBS - 1; i++)
                if (byte_idx == IDX_W'(ADDR_BYTES + i))
                    hdr_nib[i] <= dec_data;
            if (byte_idx == IDX_W'(ADDR_BYTES))
                hdr_bad <= dec_unc;
            else if (byte_idx > IDX_W'(ADDR_BYTES) && byte_idx < IDX_W'(HDR_LAST))
                hdr_bad <= hdr_bad | dec_unc;
        end
    end

    // Purpose: label registers, loaded from the cache for rows or from a fresh header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lab_mag     <= '0;
            lab_row     <= '0;
            lab_entry   <= '0;
            lab_nondisp <= 1'b0;
        end else if (row_load) begin
            lab_mag     <= mag_report(new_mag);
            lab_row     <= new_row;
            lab_entry   <= rd_entry;
            lab_nondisp <= new_row >= ROW_W'(FIRST_NONDISP_ROW);
        end else if (cache_we) begin
            lab_mag     <= mag_report(cur_mag);
            lab_row     <= '0;
            lab_entry   <= wr_entry;
            lab_nondisp <= 1'b0;
        end
    end

    // Purpose: emitted byte stream and the header-stored pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_col    <= '0;
            out_byte   <= '0;
            out_perr   <= 1'b0;
            hdr_stored <= 1'b0;
        end else begin
            out_valid  <= emit;
            hdr_stored <= cache_we;
            if (emit) begin
                out_col  <= COL_W'(byte_idx - IDX_W'(ADDR_BYTES));
                out_byte <= cur_nondisp ? in_byte : pc_char;
                out_perr <= cur_nondisp ? 1'b0 : pc_err;
            end
        end
    end

    // Purpose: drive label ports.
    always_comb begin
        out_mag     = lab_mag;
        out_row     = lab_row;
        out_page    = lab_entry.page;
        out_sub     = lab_entry.sub;
        out_serial  = lab_entry.serial;
        out_known   = lab_entry.known;
        out_nondisp = lab_nondisp;
    end

    a_r1_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> !out_valid);

    a_r8_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_col <= COL_W'(PKT_BYTES - ADDR_BYTES - 1));

    a_r8_header_cols: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row == '0) |-> out_col >= COL_W'(HDR_LAST + 1 - ADDR_BYTES));

    a_r7_display_stripped: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nondisp) |-> !out_byte[7]);

    a_r7_space_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_perr && ERR_TO_SPACE) |-> out_byte == 8'h20);

    a_r9_no_parity_nondisp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nondisp) |-> !out_perr);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_stored |=> !hdr_stored);

    a_r4_header_labels: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_stored |-> (out_known && out_row == '0 && out_mag != '0));

    a_r3_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag >= 4'd1 && out_mag <= 4'd8));
endmodule

// File: tb/tb_tpd_packet_decoder.sv
module tb_tpd_packet_decoder;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n, in_frame, in_valid;
    logic [7:0]  in_byte;
    logic        out_valid, out_perr, out_serial, out_known, out_nondisp, hdr_stored;
    logic [5:0]  out_col;
    logic [7:0]  out_byte, out_page;
    logic [3:0]  out_mag;
    logic [4:0]  out_row;
    logic [12:0] out_sub;

    tpd_packet_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_col(out_col), .out_byte(out_byte), .out_perr(out_perr),
        .out_mag(out_mag), .out_row(out_row), .out_page(out_page), .out_sub(out_sub),
        .out_serial(out_serial), .out_known(out_known), .out_nondisp(out_nondisp),
        .hdr_stored(hdr_stored)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // model cache
    logic [7:0]  bm_page  [8];
    logic [12:0] bm_sub   [8];
    logic        bm_ser   [8];
    logic        bm_known [8];

    // per packet stimulus and expectations
    logic [7:0] pkt    [0:42];
    bit         e_v    [0:42];
    logic [7:0] e_byte [0:42];
    bit         e_perr [0:42];
    bit         e_hdr;
    logic [3:0] l_mag;
    logic [4:0] l_row;
    logic [7:0] l_page;
    logic [12:0] l_sub;
    bit         l_ser, l_known, l_nd;

    task automatic ck(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ham_enc(input logic [3:0] d);
        logic [7:0] b;
        b[1] = d[0]; b[3] = d[1]; b[5] = d[2]; b[7] = d[3];
        b[0] = ~(d[0] ^ d[2] ^ d[3]);
        b[2] = ~(d[0] ^ d[1] ^ d[3]);
        b[4] = ~(d[0] ^ d[1] ^ d[2]);
        b[6] = 1'b0;
        b[6] = ~(^b);
        return b;
    endfunction

    // brute force nearest codeword: {bad, nibble}
    function automatic logic [4:0] ham_nearest(input logic [7:0] b);
        for (int v = 0; v < 16; v++)
            if ($countones(b ^ ham_enc(4'(v))) <= 1) return {1'b0, 4'(v)};
        return 5'h10;
    endfunction

    function automatic logic [7:0] odd_byte(input logic [6:0] c);
        return {~(^c), c};
    endfunction

    function automatic logic [7:0] flip_bits(input logic [7:0] b, input int n);
        logic [7:0] m = '0;
        while ($countones(m) < n) m[$urandom % 8] = 1'b1;
        return b ^ m;
    endfunction

    task automatic reset_model();
        for (int i = 0; i < 8; i++) begin
            bm_page[i] = '0; bm_sub[i] = '0; bm_ser[i] = 0; bm_known[i] = 0;
        end
    endtask

    task automatic check_step(input int k);
        if (k < 0) begin
            ck("R1", "idle out_valid", 32'(out_valid), 0);
            ck("R4", "idle hdr_stored", 32'(hdr_stored), 0);
            return;
        end
        ck("R8", "out_valid", 32'(out_valid), 32'(e_v[k]));
        ck("R4", "hdr_stored", 32'(hdr_stored), 32'(k == 9 && e_hdr));
        if (e_v[k] && out_valid) begin
            ck("R8", "out_col", 32'(out_col), 32'(k - 2));
            ck(l_nd ? "R9" : "R7", "out_byte", 32'(out_byte), 32'(e_byte[k]));
            ck(l_nd ? "R9" : "R7", "out_perr", 32'(out_perr), 32'(e_perr[k]));
            ck("R3", "out_mag", 32'(out_mag), 32'(l_mag));
            ck("R3", "out_row", 32'(out_row), 32'(l_row));
            ck("R6", "out_page", 32'(out_page), 32'(l_page));
            ck("R6", "out_sub", 32'(out_sub), 32'(l_sub));
            ck("R11", "out_serial", 32'(out_serial), 32'(l_ser));
            ck("R6", "out_known", 32'(out_known), 32'(l_known));
            ck("R9", "out_nondisp", 32'(out_nondisp), 32'(l_nd));
        end
    endtask

    task automatic send(input logic [2:0] m, input logic [4:0] r, input logic [31:0] hn,
                        input int addr_flips, input int hdr_pos, input int hdr_flips,
                        input int perr_pct, input bit stalls, input int nsend);
        logic [4:0] a0, a1, dn;
        logic [3:0] dh [8];
        logic [2:0] dm;
        logic [4:0] dr;
        bit ok_a, ok_h;
        int prev;
        pkt[0] = ham_enc({r[0], m});
        pkt[1] = ham_enc(r[4:1]);
        for (int i = 0; i < 8; i++) pkt[2+i] = ham_enc(hn[4*i +: 4]);
        for (int k = 2; k < 43; k++) begin
            if (r != 0 || k >= 10) begin
                if (r >= 25) pkt[k] = 8'($urandom);
                else pkt[k] = odd_byte(7'($urandom));
                if (int'($urandom % 100) < perr_pct) pkt[k] = flip_bits(pkt[k], 1);
            end
        end
        if (addr_flips > 0) begin
            int which = int'($urandom % 2);
            pkt[which] = flip_bits(pkt[which], addr_flips);
        end
        if (hdr_pos >= 0) pkt[2+hdr_pos] = flip_bits(pkt[2+hdr_pos], hdr_flips);

        a0 = ham_nearest(pkt[0]);
        a1 = ham_nearest(pkt[1]);
        ok_a = !a0[4] && !a1[4];
        dm = a0[2:0];
        dr = {a1[3:0], a0[3]};
        ok_h = 1;
        for (int i = 0; i < 8; i++) begin
            dn = ham_nearest(pkt[2+i]);
            dh[i] = dn[3:0];
            if (dn[4]) ok_h = 0;
        end
        if (!(ok_a && dr == 0)) ok_h = 0;
        e_hdr = ok_h;
        l_mag = (dm == 0) ? 4'd8 : {1'b0, dm};
        l_row = dr;
        l_nd  = dr >= 25;
        if (dr != 0) begin
            l_page = bm_page[dm]; l_sub = bm_sub[dm]; l_ser = bm_ser[dm]; l_known = bm_known[dm];
        end else begin
            l_page = {dh[1], dh[0]};
            l_sub  = {dh[5][1:0], dh[4], dh[3][2:0], dh[2]};
            l_ser  = dh[7][0];
            l_known = 1;
            if (ok_h && nsend >= 10) begin
                bm_page[dm] = l_page; bm_sub[dm] = l_sub; bm_ser[dm] = l_ser; bm_known[dm] = 1;
            end
        end
        for (int k = 0; k < 43; k++) begin
            e_v[k] = ok_a && k >= 2 && k < 42 && k < nsend && (dr != 0 || (ok_h && k >= 10));
            if (dr >= 25) begin
                e_byte[k] = pkt[k]; e_perr[k] = 0;
            end else if (^pkt[k]) begin
                e_byte[k] = {1'b0, pkt[k][6:0]}; e_perr[k] = 0;
            end else begin
                e_byte[k] = 8'h20; e_perr[k] = 1;
            end
        end

        prev = -1;
        for (int k = 0; k < nsend; k++) begin
            if (stalls && ($urandom % 4 == 0) && k > 0) begin
                @(negedge clk); check_step(prev); prev = -1;
                in_valid = 0;
            end
            @(negedge clk); check_step(prev);
            in_frame = 1; in_valid = 1; in_byte = pkt[k]; prev = k;
        end
        @(negedge clk); check_step(prev);
        in_valid = 0; in_frame = 0;
        @(negedge clk); check_step(-1);
    endtask

    task automatic check_reset_state();
        ck("R10", "out_valid", 32'(out_valid), 0);
        ck("R10", "out_mag", 32'(out_mag), 0);
        ck("R10", "out_page", 32'(out_page), 0);
        ck("R10", "out_sub", 32'(out_sub), 0);
        ck("R10", "out_known", 32'(out_known), 0);
        ck("R10", "hdr_stored", 32'(hdr_stored), 0);
        ck("R10", "out_byte", 32'(out_byte), 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; in_frame = 0; in_valid = 0; in_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        reset_model();
        @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; in_frame = 0; in_valid = 0; in_byte = 0;
        do_reset();

        // R6/R10: row before any header is unknown
        send(3'd5, 5'd4, 32'h0, 0, -1, 0, 0, 0, 42);
        // R4: header mag 3, page 45, then same-magazine row back to back
        send(3'd3, 5'd0, 32'h8123_4a45, 0, -1, 0, 0, 0, 42);
        send(3'd3, 5'd7, 32'h0, 0, -1, 0, 0, 0, 42);
        // R3: magazine code 0 reported as 8
        send(3'd0, 5'd0, 32'h0765_4321, 0, -1, 0, 0, 0, 42);
        send(3'd0, 5'd12, 32'h0, 0, -1, 0, 0, 0, 42);
        // R2: single-bit errors in address and every header byte are corrected
        send(3'd2, 5'd0, 32'h1f0e_2d3c, 1, -1, 0, 0, 0, 42);
        for (int i = 0; i < 8; i++) send(3'd6, 5'd0, 32'(32'h1357_9bdf + i), 0, i, 1, 0, 0, 42);
        send(3'd6, 5'd1, 32'h0, 0, -1, 0, 0, 0, 42);
        // R5: double error in a subcode nibble discards the header
        send(3'd3, 5'd0, 32'hffff_ffff, 0, 3, 2, 0, 0, 42);
        send(3'd3, 5'd2, 32'h0, 0, -1, 0, 0, 0, 42);
        // R3: uncorrectable address yields nothing
        send(3'd1, 5'd9, 32'h0, 2, -1, 0, 0, 0, 42);
        // R9: non-displayable row passes raw bytes
        send(3'd3, 5'd26, 32'h0, 0, -1, 0, 30, 0, 42);
        // R7: heavy parity errors on a display row
        send(3'd3, 5'd20, 32'h0, 0, -1, 0, 50, 0, 42);
        // R11: header for mag 4 leaves mag 3 labels intact
        send(3'd4, 5'd0, 32'h0aaa_5599, 0, -1, 0, 0, 0, 42);
        send(3'd3, 5'd5, 32'h0, 0, -1, 0, 0, 0, 42);
        // R1: extra byte beyond 42, truncated header, stalls
        send(3'd7, 5'd0, 32'h1234_5678, 0, -1, 0, 0, 1, 43);
        send(3'd7, 5'd0, 32'h8765_4321, 0, -1, 0, 0, 0, 6);
        send(3'd7, 5'd3, 32'h0, 0, -1, 0, 0, 1, 42);
        send(3'd7, 5'd3, 32'h0, 0, -1, 0, 0, 0, 20);

        for (int p = 0; p < 260; p++) begin
            logic [4:0] r;
            int sel, af, hp, hf, ns, e;
            sel = int'($urandom % 10);
            if (sel < 3 || sel == 9) r = 0;
            else if (sel < 8) r = 5'(1 + $urandom % 24);
            else r = 5'(25 + $urandom % 7);
            e = int'($urandom % 20);
            af = (e == 0) ? 2 : (e < 3) ? 1 : 0;
            e = int'($urandom % 20);
            hp = (e < 4) ? int'($urandom % 8) : -1;
            hf = (e == 0) ? 2 : 1;
            e = int'($urandom % 20);
            ns = (e == 0) ? 43 : (e == 1) ? int'(3 + $urandom % 39) : 42;
            send(3'($urandom % 8), r, $urandom, af, hp, hf, 5, 1'($urandom % 2), ns);
            if (p == 130) do_reset();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule